// File: doc/BRIEF.md
# Asynchronous SRAM Port to SDRAM Bridge

This block lets a processor reach a shared SDRAM frame store as if it were a plain asynchronous static RAM. The processor drives chip select, output enable, write enable, an address and write data with no clock. The bridge brings the three strobes into the memory clock domain, splits the flat address into bank, row and column, and runs one complete SDRAM access per strobe assertion. That access is an activate, then a read or write with auto-precharge, then a recovery gap. A ready output tells the processor when read data is valid or when a write is committed.

The SDRAM is also filled by a video capture burst writer. That writer raises a request and gets a grant whenever the bridge is idle. While the writer holds the grant, the bridge drives only no-operation commands and any processor access waits. The actual command mux toward the memory pins sits outside this block and is steered by the grant.

Top module: `asram_sdram_bridge`

## Requirements
- R1: While rst_n is low, and in the first cycle after it rises, these outputs hold their idle values: cpu_ready is 0, sd_dq_oe is 0, cap_gnt is 0, and sd_cmd is NOP. Commands are coded on sd_cmd as {cs_n, ras_n, cas_n, we_n}: NOP 4'b0111, ACTIVATE 4'b0011, READ 4'b0101, WRITE 4'b0100.
- R2: Each of cpu_cs_n, cpu_oe_n and cpu_we_n passes through a two-flop synchroniser. Suppose the strobes of an access settle before rising edge k while the bridge is idle. Then ACTIVATE is presented in the cycle that follows edge k+2, and sd_cmd stays NOP before that.
- R3: The address is split as column = cpu_addr[7:0], bank = cpu_addr[9:8] and row = cpu_addr[21:10]. ACTIVATE drives the bank on sd_ba and the row on sd_addr. READ and WRITE drive the same bank on sd_ba and the column on sd_addr[7:0].
- R4: During every READ and WRITE, sd_addr[10] is 1, which requests auto-precharge.
- R5: READ or WRITE follows its ACTIVATE by exactly T_RCD cycles (default 2).
- R6: An access is a write whenever cpu_we_n is low, whatever cpu_oe_n is doing. In the WRITE cycle, sd_dq_out carries cpu_wdata and sd_dq_oe is 1. sd_dq_oe is 0 in every other cycle.
- R7: An access is a read when cpu_oe_n is low and cpu_we_n is high. sd_dq_in is sampled at the CL-th rising edge (default 2) after the edge that issues READ. The sampled value is held on cpu_rdata while cpu_ready is high.
- R8: cpu_ready is 0 while an access is in progress. It rises T_TAIL cycles (default 3) after the READ or WRITE command cycle, or after the read sample. It stays high while the strobes are held, and it is 0 again at the third rising edge after cpu_cs_n is released.
- R9: If cap_req is high while the bridge is idle, cap_gnt rises at the next edge and stays high until cap_req falls. During that time sd_cmd is NOP and a pending processor access waits. The access then completes with correct data.
- R10: If a processor access and cap_req are both pending in the same idle cycle, the capture writer is granted first.
- R11: Each strobe assertion produces exactly one ACTIVATE. Holding the strobes after cpu_ready has risen issues no further command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | SDRAM clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_cs_n | input | 1 | Asynchronous chip select, active low |
| cpu_oe_n | input | 1 | Asynchronous output enable, active low |
| cpu_we_n | input | 1 | Asynchronous write enable, active low |
| cpu_addr | input | 22 | Flat word address |
| cpu_wdata | input | 16 | Write data |
| cpu_rdata | output | 16 | Read data, valid while cpu_ready is high |
| cpu_ready | output | 1 | Access complete; low means wait |
| cap_req | input | 1 | Capture writer asks for the memory |
| cap_gnt | output | 1 | Capture writer owns the memory |
| sd_cmd | output | 4 | {cs_n, ras_n, cas_n, we_n} command |
| sd_ba | output | 2 | SDRAM bank address |
| sd_addr | output | 12 | SDRAM row / column address |
| sd_dq_out | output | 16 | Write data toward SDRAM |
| sd_dq_oe | output | 1 | Drive enable for sd_dq_out |
| sd_dq_in | input | 16 | Read data from SDRAM |

## Verification
The assertions take three things for granted. First, the processor holds address and write data stable for as long as its strobes are asserted. Second, it keeps the strobes released for at least two clock cycles between accesses. Third, cap_req is synchronous to clk. The bench changes every input only on the falling clock edge. It fixes address and data before it lowers the strobes, and it keeps them until ready has been seen low again. It also waits several cycles between accesses. A behavioural memory model in the bench answers READ after CL edges and puts a marker value on sd_dq_in in every other cycle, so a capture at the wrong edge shows up as a miscompare.

// File: rtl/sdbr_pkg.sv
// Shared types for the asynchronous-SRAM to SDRAM bridge.
// Assumes a single-data-rate SDRAM with {cs_n,ras_n,cas_n,we_n} commands.
package sdbr_pkg;

    typedef enum logic [3:0] {
        CMD_NOP = 4'b0111,
        CMD_ACT = 4'b0011,
        CMD_RD  = 4'b0101,
        CMD_WR  = 4'b0100
    } sd_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OWNED,
        ST_ACT,
        ST_RCD,
        ST_CMD,
        ST_LAT,
        ST_TAIL
    } seq_state_e;

endpackage

// File: rtl/strobe_sync.sv
// Two-flop synchroniser bank for asynchronous strobe inputs.
// Assumes strobes are idle at RST_VAL; each bit is synchronised on its own.
module strobe_sync #(
    parameter int  W       = 3,
    parameter bit  RST_VAL = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);

    generate
        for (genvar i = 0; i < W; i++) begin : g_bit
            logic meta_q;
            logic stab_q;

            // Two register stages per strobe to settle metastability.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    meta_q <= RST_VAL;
                    stab_q <= RST_VAL;
                end else begin
                    meta_q <= async_in[i];
                    stab_q <= meta_q;
                end
            end

            assign sync_out[i] = stab_q;
        end
    endgenerate

endmodule

// File: rtl/addr_split.sv
// Splits a flat word address into SDRAM row, bank and column fields.
// Layout: column in the low bits, then bank, then row in the high bits.
module addr_split #(
    parameter int ROWW = 12,
    parameter int BAW  = 2,
    parameter int COLW = 8,
    localparam int AW  = ROWW + BAW + COLW
) (
    input  logic [AW-1:0]   flat_addr,
    output logic [ROWW-1:0] row,
    output logic [BAW-1:0]  bank,
    output logic [COLW-1:0] col
);

    // Pure field extraction; no state.
    always_comb begin
        col  = flat_addr[COLW-1:0];
        bank = flat_addr[COLW +: BAW];
        row  = flat_addr[COLW+BAW +: ROWW];
    end

endmodule

// File: rtl/access_seq.sv
// Single-word SDRAM access sequencer with capture-writer arbitration.
// Runs ACTIVATE, READ/WRITE with auto-precharge and a recovery gap for each
// processor request, and holds ready until the request is withdrawn.
// Assumes request fields are stable while acc_req is high and that the
// capture writer asks with a request synchronous to clk.
module access_seq
    import sdbr_pkg::*;
#(
    parameter int DW     = 16,
    parameter int ROWW   = 12,
    parameter int BAW    = 2,
    parameter int COLW   = 8,
    parameter int AP_BIT = 10,
    parameter int T_RCD  = 2,
    parameter int CL     = 2,
    parameter int T_TAIL = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            acc_req,
    input  logic            acc_wr,
    input  logic [ROWW-1:0] req_row,
    input  logic [BAW-1:0]  req_bank,
    input  logic [COLW-1:0] req_col,
    input  logic [DW-1:0]   req_wdata,
    input  logic            cap_req,
    output logic            cap_gnt,
    output logic [DW-1:0]   rdata,
    output logic            ready,
    output logic [3:0]      sd_cmd,
    output logic [BAW-1:0]  sd_ba,
    output logic [ROWW-1:0] sd_addr,
    output logic [DW-1:0]   sd_dq_out,
    output logic            sd_dq_oe,
    input  logic [DW-1:0]   sd_dq_in
);

    localparam int CNT_MAX  = (T_RCD > CL) ? ((T_RCD > T_TAIL) ? T_RCD : T_TAIL)
                                           : ((CL > T_TAIL) ? CL : T_TAIL);
    localparam int CW       = $clog2(CNT_MAX + 1);
    localparam int RCD_LOAD = (T_RCD > 1) ? T_RCD - 2 : 0;

    seq_state_e        state_q;
    logic [CW-1:0]     cnt_q;
    logic [ROWW-1:0]   row_q;
    logic [BAW-1:0]    bank_q;
    logic [COLW-1:0]   col_q;
    logic [DW-1:0]     wd_q;
    logic              wr_q;
    logic              served_q;
    logic              tail_end;

    assign tail_end = (state_q == ST_TAIL) && (cnt_q == '0);

    // Sequencer state and wait counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (cap_req) begin
                        state_q <= ST_OWNED;
                    end else if (acc_req && !served_q) begin
                        state_q <= ST_ACT;
                    end
                end
                ST_OWNED: begin
                    if (!cap_req) state_q <= ST_IDLE;
                end
                ST_ACT: begin
                    if (T_RCD > 1) begin
                        state_q <= ST_RCD;
                        cnt_q   <= CW'(RCD_LOAD);
                    end else begin
                        state_q <= ST_CMD;
                    end
                end
                ST_RCD: begin
                    if (cnt_q == '0) state_q <= ST_CMD;
                    else             cnt_q   <= cnt_q - 1'b1;
                end
                ST_CMD: begin
                    if (wr_q) begin
                        state_q <= ST_TAIL;
                        cnt_q   <= CW'(T_TAIL - 1);
                    end else begin
                        state_q <= ST_LAT;
                        cnt_q   <= CW'(CL - 1);
                    end
                end
                ST_LAT: begin
                    if (cnt_q == '0) begin
                        state_q <= ST_TAIL;
                        cnt_q   <= CW'(T_TAIL - 1);
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                ST_TAIL: begin
                    if (cnt_q == '0) state_q <= ST_IDLE;
                    else             cnt_q   <= cnt_q - 1'b1;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Latch the request fields when an access is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q  <= '0;
            bank_q <= '0;
            col_q  <= '0;
            wd_q   <= '0;
            wr_q   <= 1'b0;
        end else if (state_q == ST_IDLE && !cap_req && acc_req && !served_q) begin
            row_q  <= req_row;
            bank_q <= req_bank;
            col_q  <= req_col;
            wd_q   <= req_wdata;
            wr_q   <= acc_wr;
        end
    end

    // Capture read data CL edges after the READ edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (state_q == ST_LAT && cnt_q == '0) begin
            rdata <= sd_dq_in;
        end
    end

    // Completion flag: set at the end of recovery, cleared on release.
    always_ff @(posedge clk) begin
        if (!rst_n)        served_q <= 1'b0;
        else if (!acc_req) served_q <= 1'b0;
        else if (tail_end) served_q <= 1'b1;
    end

    assign ready   = served_q;
    assign cap_gnt = (state_q == ST_OWNED);

    // Command, address and data-bus drive per state.
    always_comb begin
        sd_cmd    = CMD_NOP;
        sd_ba     = bank_q;
        sd_addr   = '0;
        sd_dq_out = wd_q;
        sd_dq_oe  = 1'b0;
        unique case (state_q)
            ST_ACT: begin
                sd_cmd  = CMD_ACT;
                sd_addr = row_q;
            end
            ST_CMD: begin
                sd_cmd                = wr_q ? CMD_WR : CMD_RD;
                sd_addr[COLW-1:0]     = col_q;
                sd_addr[AP_BIT]       = 1'b1;
                sd_dq_oe              = wr_q;
            end
            default: ;
        endcase
    end

    // Checker-side counter of cycles since the last ACTIVATE.
    localparam int SW     = $clog2(T_RCD + 2);
    localparam int SA_MAX = T_RCD + 1;
    logic [SW-1:0] since_act_q;
    always_ff @(posedge clk) begin
        if (!rst_n)                       since_act_q <= SW'(SA_MAX);
        else if (sd_cmd == CMD_ACT)       since_act_q <= SW'(1);
        else if (since_act_q != SW'(SA_MAX)) since_act_q <= since_act_q + 1'b1;
    end

    p_idle_cmd_after_reset_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> (sd_cmd == CMD_NOP) && !ready && !cap_gnt);

    p_ap_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_cmd == CMD_RD || sd_cmd == CMD_WR) |-> sd_addr[AP_BIT]);

    p_rcd_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_cmd == CMD_RD || sd_cmd == CMD_WR) |-> since_act_q == SW'(T_RCD));

    p_oe_only_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sd_dq_oe |-> sd_cmd == CMD_WR);

    p_ready_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !acc_req) |=> !ready);

    p_silent_when_granted_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cap_gnt |-> sd_cmd == CMD_NOP);

    p_gnt_follows_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cap_gnt) |-> $past(cap_req));

    p_no_retrigger_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> sd_cmd != CMD_ACT);

endmodule

// File: rtl/asram_sdram_bridge.sv
// Top level: asynchronous SRAM-style slave port mapped onto SDRAM.
// Synchronises the strobes, splits the address and hands one request at a
// time to the sequencer, which also arbitrates against the capture writer.
// Assumes address and write data stay stable while the strobes are active.
module asram_sdram_bridge #(
    parameter int DW     = 16,
    parameter int ROWW   = 12,
    parameter int BAW    = 2,
    parameter int COLW   = 8,
    parameter int AP_BIT = 10,
    parameter int T_RCD  = 2,
    parameter int CL     = 2,
    parameter int T_TAIL = 3,
    localparam int AW    = ROWW + BAW + COLW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cpu_cs_n,
    input  logic            cpu_oe_n,
    input  logic            cpu_we_n,
    input  logic [AW-1:0]   cpu_addr,
    input  logic [DW-1:0]   cpu_wdata,
    output logic [DW-1:0]   cpu_rdata,
    output logic            cpu_ready,
    input  logic            cap_req,
    output logic            cap_gnt,
    output logic [3:0]      sd_cmd,
    output logic [BAW-1:0]  sd_ba,
    output logic [ROWW-1:0] sd_addr,
    output logic [DW-1:0]   sd_dq_out,
    output logic            sd_dq_oe,
    input  logic [DW-1:0]   sd_dq_in
);

    logic [2:0]      strobes_s;
    logic            cs_s, oe_s, we_s;
    logic            acc_req, acc_wr;
    logic [ROWW-1:0] map_row;
    logic [BAW-1:0]  map_bank;
    logic [COLW-1:0] map_col;

    strobe_sync #(.W(3), .RST_VAL(1'b1)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({cpu_cs_n, cpu_oe_n, cpu_we_n}),
        .sync_out (strobes_s)
    );

    assign {cs_s, oe_s, we_s} = strobes_s;

    // An access is pending when selected and either strobe is active; write wins.
    always_comb begin
        acc_req = !cs_s && (!oe_s || !we_s);
        acc_wr  = !we_s;
    end

    addr_split #(.ROWW(ROWW), .BAW(BAW), .COLW(COLW)) u_map (
        .flat_addr (cpu_addr),
        .row       (map_row),
        .bank      (map_bank),
        .col       (map_col)
    );

    access_seq #(
        .DW(DW), .ROWW(ROWW), .BAW(BAW), .COLW(COLW), .AP_BIT(AP_BIT),
        .T_RCD(T_RCD), .CL(CL), .T_TAIL(T_TAIL)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_req   (acc_req),
        .acc_wr    (acc_wr),
        .req_row   (map_row),
        .req_bank  (map_bank),
        .req_col   (map_col),
        .req_wdata (cpu_wdata),
        .cap_req   (cap_req),
        .cap_gnt   (cap_gnt),
        .rdata     (cpu_rdata),
        .ready     (cpu_ready),
        .sd_cmd    (sd_cmd),
        .sd_ba     (sd_ba),
        .sd_addr   (sd_addr),
        .sd_dq_out (sd_dq_out),
        .sd_dq_oe  (sd_dq_oe),
        .sd_dq_in  (sd_dq_in)
    );

endmodule

// File: tb/tb_asram_sdram_bridge.sv
`timescale 1ns/1ps
// Bench: vector table of processor accesses, then directed tests.
module tb_asram_sdram_bridge;

    localparam logic [3:0] C_NOP = 4'b0111;
    localparam logic [3:0] C_ACT = 4'b0011;
    localparam logic [3:0] C_RD  = 4'b0101;
    localparam logic [3:0] C_WR  = 4'b0100;
    localparam int T_RCD = 2;
    localparam int CL    = 2;

    typedef struct packed {
        logic        wr;
        logic [21:0] addr;
        logic [15:0] data;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 22'h0003FF, 16'h1234},
        '{1'b1, 22'h3FFC00, 16'hBEEF},
        '{1'b1, 22'h155155, 16'h0F0F},
        '{1'b0, 22'h0003FF, 16'h1234},
        '{1'b0, 22'h3FFC00, 16'hBEEF},
        '{1'b1, 22'h0003FF, 16'h4321},
        '{1'b0, 22'h155155, 16'h0F0F},
        '{1'b0, 22'h0003FF, 16'h4321},
        '{1'b0, 22'h2AA0AA, 16'h0000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_cs_n = 1'b1, cpu_oe_n = 1'b1, cpu_we_n = 1'b1;
    logic [21:0] cpu_addr = '0;
    logic [15:0] cpu_wdata = '0;
    logic [15:0] cpu_rdata;
    logic        cpu_ready;
    logic        cap_req = 1'b0;
    logic        cap_gnt;
    logic [3:0]  sd_cmd;
    logic [1:0]  sd_ba;
    logic [11:0] sd_addr;
    logic [15:0] sd_dq_out;
    logic        sd_dq_oe;
    logic [15:0] sd_dq_in = 16'hDEAD;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    asram_sdram_bridge dut (
        .clk(clk), .rst_n(rst_n),
        .cpu_cs_n(cpu_cs_n), .cpu_oe_n(cpu_oe_n), .cpu_we_n(cpu_we_n),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
        .cap_req(cap_req), .cap_gnt(cap_gnt),
        .sd_cmd(sd_cmd), .sd_ba(sd_ba), .sd_addr(sd_addr),
        .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe), .sd_dq_in(sd_dq_in)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Behavioural SDRAM model; checks commands against the access in flight.
    logic [21:0] cur_addr = '0;
    logic [15:0] cur_data = '0;
    logic [15:0] mem [logic [21:0]];
    logic [11:0] open_row [4];
    int          since_act = 100;
    int          pend = 0;
    int          act_count = 0;
    logic [15:0] rd_val = '0;

    always @(negedge clk) begin
        if (pend > 0) begin
            pend--;
            sd_dq_in = (pend == 0) ? rd_val : 16'hDEAD;
        end else begin
            sd_dq_in = 16'hDEAD;
        end
        since_act++;
        if (rst_n) begin
            if (sd_dq_oe && sd_cmd != C_WR)
                chk(1'b0, "R6 oe outside WRITE", {28'h0, sd_cmd}, {28'h0, C_WR});
            case (sd_cmd)
                C_ACT: begin
                    act_count++;
                    since_act = 0;
                    open_row[sd_ba] = sd_addr;
                    chk(sd_ba == cur_addr[9:8] && sd_addr == cur_addr[21:10], "R3 activate bank/row",
                        {18'h0, sd_ba, sd_addr}, {18'h0, cur_addr[9:8], cur_addr[21:10]});
                end
                C_WR, C_RD: begin
                    chk(since_act == T_RCD, "R5 activate-to-command gap", since_act, T_RCD);
                    chk(sd_addr[10] == 1'b1, "R4 auto-precharge bit", sd_addr[10], 1);
                    chk(sd_ba == cur_addr[9:8] && sd_addr[7:0] == cur_addr[7:0], "R3 column/bank",
                        {22'h0, sd_ba, sd_addr[7:0]}, {22'h0, cur_addr[9:8], cur_addr[7:0]});
                    if (sd_cmd == C_WR) begin
                        chk(sd_dq_oe && sd_dq_out == cur_data, "R6 write data",
                            {15'h0, sd_dq_oe, sd_dq_out}, {15'h0, 1'b1, cur_data});
                        mem[{open_row[sd_ba], sd_ba, sd_addr[7:0]}] = sd_dq_out;
                    end else begin
                        rd_val = mem.exists({open_row[sd_ba], sd_ba, sd_addr[7:0]}) ?
                                 mem[{open_row[sd_ba], sd_ba, sd_addr[7:0]}] : 16'h0000;
                        pend = CL;
                    end
                end
                default: ;
            endcase
        end
    end

    task automatic drive_access(input bit wr, input bit both, input logic [21:0] a, input logic [15:0] d);
        @(negedge clk);
        cur_addr  = a;
        cur_data  = d;
        cpu_addr  = a;
        cpu_wdata = d;
        cpu_cs_n  = 1'b0;
        cpu_we_n  = !wr;
        cpu_oe_n  = !(!wr || both);
    endtask

    task automatic wait_ready(input string req);
        int n = 0;
        while (!cpu_ready && n < 60) begin
            @(negedge clk);
            n++;
        end
        if (!cpu_ready) chk(1'b0, req, 0, 1);
    endtask

    task automatic release_check();
        @(negedge clk);
        cpu_cs_n = 1'b1; cpu_oe_n = 1'b1; cpu_we_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(cpu_ready == 1'b1, "R8 ready held two edges after release", cpu_ready, 1);
        @(negedge clk);
        chk(cpu_ready == 1'b0, "R8 ready low at third edge after release", cpu_ready, 0);
        repeat (2) @(negedge clk);
    endtask

    task automatic do_access(input bit wr, input bit both, input logic [21:0] a, input logic [15:0] d);
        drive_access(wr, both, a, d);
        @(negedge clk);
        chk(cpu_ready == 1'b0, "R8 ready low during access", cpu_ready, 0);
        wait_ready("R8 ready never rose");
        if (!wr)
            chk(cpu_rdata == d, "R7 read data", cpu_rdata, d);
        release_check();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int acts0;
        // R1: outputs idle during reset, even with cap_req raised.
        cap_req = 1'b1;
        repeat (3) @(negedge clk);
        chk(cpu_ready == 0 && sd_cmd == C_NOP && sd_dq_oe == 0 && cap_gnt == 0,
            "R1 idle outputs in reset", {cpu_ready, sd_cmd, sd_dq_oe, cap_gnt}, {1'b0, C_NOP, 2'b00});
        cap_req = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        chk(cpu_ready == 0 && sd_cmd == C_NOP && sd_dq_oe == 0 && cap_gnt == 0,
            "R1 idle outputs after reset", {cpu_ready, sd_cmd, sd_dq_oe, cap_gnt}, {1'b0, C_NOP, 2'b00});
        repeat (2) @(negedge clk);

        // Vector table: writes and read-backs across banks and rows (R3..R8).
        for (int i = 0; i < NV; i++) begin
            do_access(VECS[i].wr, 1'b0, VECS[i].addr, VECS[i].data);
        end

        // R6: both strobes low is a write.
        do_access(1'b1, 1'b1, 22'h0ABCDE, 16'h5AA5);
        do_access(1'b0, 1'b0, 22'h0ABCDE, 16'h5AA5);

        // R2: ACTIVATE appears in the cycle after the third edge.
        drive_access(1'b0, 1'b0, 22'h155155, 16'h0F0F);
        @(negedge clk);
        chk(sd_cmd == C_NOP, "R2 no command one edge after strobe", sd_cmd, C_NOP);
        @(negedge clk);
        chk(sd_cmd == C_NOP, "R2 no command two edges after strobe", sd_cmd, C_NOP);
        @(negedge clk);
        chk(sd_cmd == C_ACT, "R2 activate three edges after strobe", sd_cmd, C_ACT);
        wait_ready("R2 ready never rose");
        chk(cpu_rdata == 16'h0F0F, "R2 read data", cpu_rdata, 16'h0F0F);
        // R11 and R7: holding strobes issues nothing and data stays.
        acts0 = act_count;
        repeat (12) @(negedge clk);
        chk(act_count == acts0, "R11 no extra activate while held", act_count, acts0);
        chk(cpu_ready && cpu_rdata == 16'h0F0F, "R7 data held while ready",
            {15'h0, cpu_ready, cpu_rdata}, {15'h0, 1'b1, 16'h0F0F});
        release_check();

        // R9: writer granted from idle; processor waits during the burst.
        @(negedge clk);
        cap_req = 1'b1;
        @(negedge clk);
        chk(cap_gnt == 1'b1, "R9 grant one edge after request", cap_gnt, 1);
        drive_access(1'b0, 1'b0, 22'h3FFC00, 16'hBEEF);
        begin
            bit quiet = 1'b1;
            for (int k = 0; k < 10; k++) begin
                @(negedge clk);
                if (sd_cmd != C_NOP || cpu_ready || !cap_gnt) quiet = 1'b0;
            end
            chk(quiet, "R9 bridge silent while writer owns memory", quiet, 1);
        end
        cap_req = 1'b0;
        @(negedge clk);
        chk(cap_gnt == 1'b0, "R9 grant drops after request", cap_gnt, 0);
        wait_ready("R9 access never completed");
        chk(cpu_rdata == 16'hBEEF, "R9 delayed read data", cpu_rdata, 16'hBEEF);
        release_check();

        // R10: simultaneous pending requests, writer wins.
        drive_access(1'b0, 1'b0, 22'h0003FF, 16'h4321);
        @(negedge clk);
        @(negedge clk);
        cap_req = 1'b1;
        @(negedge clk);
        chk(cap_gnt == 1'b1 && sd_cmd == C_NOP, "R10 writer wins tie",
            {27'h0, cap_gnt, sd_cmd}, {27'h0, 1'b1, C_NOP});
        cap_req = 1'b0;
        wait_ready("R10 access never completed");
        chk(cpu_rdata == 16'h4321, "R10 read data after tie", cpu_rdata, 16'h4321);
        release_check();

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule